// File: doc/BRIEF.md
# Multi-format pixel byte serializer

This block sits at the video output edge of an image pipeline. It takes processed pixel beats from a valid/ready stream and serializes them onto an 8-bit data bus. A byte strobe marks each valid byte, a line-active signal frames each row, and a one-cycle frame pulse marks the first byte of a frame. Three encodings are supported: YCbCr 4:2:2, where one beat is a pixel pair; RGB565, where one beat is one pixel; and 10-bit raw Bayer, where one beat is a pair of neighbouring samples. A sub-mode field picks the byte order within each encoding.

The 32-bit beat word uses a fixed field layout for each format. For YCbCr the layout is Y0 `[7:0]`, Cb `[15:8]`, Y1 `[23:16]` and Cr `[31:24]`. For RGB565 it is B `[4:0]`, G `[10:5]` and R `[15:11]`. For raw it is the first sample in `[9:0]` and the second sample in `[25:16]`. The format code and sub-mode are taken only with the beat that opens a frame, so a frame never mixes encodings. The block does no colour arithmetic and inserts no embedded sync codes.

Top module: `pix_out_fmt`

## Requirements
- R1: After reset the strobe, line, frame and data outputs are 0 and `in_ready` is 1. The active setting is format 0, sub-mode 0 until a frame-opening beat loads a new one.
- R2: Format code 0 (YCbCr) sends 4 bytes per beat in one of four orders. Sub 0 gives Cb Y0 Cr Y1. Sub 1 gives Cr Y0 Cb Y1. Sub 2 gives Y0 Cb Y1 Cr. Sub 3 gives Y0 Cr Y1 Cb.
- R3: Format code 1 (RGB565) sends 2 bytes per beat. With sub bit 0 clear the bytes are {R[4:0],G[5:3]} then {G[2:0],B[4:0]}. With sub bit 0 set they are {B[4:0],G[5:3]} then {G[2:0],R[4:0]}. Sub bit 1 has no effect.
- R4: Format code 2 (raw) sends each 10-bit sample as a high byte {6'b0,D[9:8]} followed by a low byte D[7:0]. The beat's two samples go first-then-second when sub bit 0 is clear and second-then-first when it is set. Sub bit 1 has no effect.
- R5: Format code 3 behaves exactly as format code 2.
- R6: `cfg_fmt` and `cfg_sub` are sampled only on an accepted beat that has `in_sof` set. Changes at any other time leave the output order unchanged.
- R7: While no byte is being sent, the strobe is 0 and the data bus is 0. A stall in the middle of a line keeps the line signal high, and the next beat starts again at its first byte.
- R8: `out_hsync` rises with the first byte of a beat carrying `in_sol` and falls after the last byte of a beat carrying `in_eol`. `in_ready` is 0 during that last byte, so the next line starts at least 2 cycles after it.
- R9: `out_vsync` is high for exactly one cycle, together with the first byte of a beat carrying `in_sof`, and never on later lines.
- R10: The first byte appears in the cycle after a beat is accepted. Within a line, back-to-back beats produce bytes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 2 | Format code: 0 YCbCr, 1 RGB565, 2/3 raw |
| cfg_sub | input | 2 | Byte-order sub-mode |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with in_valid |
| in_sof | input | 1 | Beat opens a frame |
| in_sol | input | 1 | Beat opens a line |
| in_eol | input | 1 | Beat closes a line |
| in_word | input | 32 | Beat payload, layout by format |
| out_data | output | 8 | Serialized byte, 0 when idle |
| out_stb | output | 1 | Byte strobe |
| out_hsync | output | 1 | Line active |
| out_vsync | output | 1 | Frame-start pulse |

## Verification
One asymmetric word is run through every format and sub-mode in a single-beat frame. Each field holds a distinct byte value, so any swapped lane, wrong shift or wrong padding shows up as a wrong byte value. The ignored sub-mode bit and the aliased format code are driven with values that would give a different order if they were decoded. Multi-beat lines with continuous valid separate a correct handoff between beats from an added bubble or a missing end-of-line gap. A mid-line stall and a mid-frame configuration change check that phase and setting are held only where they should be.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = MAX_BYTES * BYTE_W;
  localparam int PH_W      = $clog2(MAX_BYTES);
  localparam int RAW_W     = 10;
  localparam int RAW_PAD   = 2 * BYTE_W - RAW_W;
  localparam int RAW_HI_LSB = WORD_W / 2;

  typedef enum logic [1:0] {
    FMT_YCC = 2'd0,
    FMT_RGB = 2'd1,
    FMT_RAW = 2'd2,
    FMT_RAX = 2'd3
  } fmt_e;

  function automatic logic [BYTE_W-1:0] lane(input logic [WORD_W-1:0] w, input int idx);
    return w[idx*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] ycc_byte(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] sub,
                                                 input logic [PH_W-1:0] ph);
    int idx;
    idx = 0;
    case (sub)
      2'd0: case (ph) 2'd0: idx = 1; 2'd1: idx = 0; 2'd2: idx = 3; default: idx = 2; endcase
      2'd1: case (ph) 2'd0: idx = 3; 2'd1: idx = 0; 2'd2: idx = 1; default: idx = 2; endcase
      2'd2: idx = int'(ph);
      default: case (ph) 2'd0: idx = 0; 2'd1: idx = 3; 2'd2: idx = 2; default: idx = 1; endcase
    endcase
    return lane(w, idx);
  endfunction

  function automatic logic [BYTE_W-1:0] rgb_byte(input logic [WORD_W-1:0] w,
                                                 input logic swap,
                                                 input logic [PH_W-1:0] ph);
    logic [4:0] r, b, lead, tail;
    logic [5:0] g;
    r = w[15:11];
    g = w[10:5];
    b = w[4:0];
    lead = swap ? b : r;
    tail = swap ? r : b;
    return ph[0] ? {g[2:0], tail} : {lead, g[5:3]};
  endfunction

  function automatic logic [BYTE_W-1:0] raw_byte(input logic [WORD_W-1:0] w,
                                                 input logic swap,
                                                 input logic [PH_W-1:0] ph);
    logic [RAW_W-1:0] s;
    s = (ph[1] ^ swap) ? w[RAW_HI_LSB +: RAW_W] : w[0 +: RAW_W];
    return ph[0] ? s[BYTE_W-1:0] : {{RAW_PAD{1'b0}}, s[RAW_W-1:BYTE_W]};
  endfunction

  function automatic logic four_byte_beat(input logic [1:0] fmt);
    return fmt_e'(fmt) != FMT_RGB;
  endfunction
endpackage

// File: rtl/pof_beat_hold.sv
module pof_beat_hold
  import pof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_eol,
  input  logic              four_next,
  output logic              ready,
  output logic              acc,
  output logic              busy,
  output logic [WORD_W-1:0] word_q,
  output logic [PH_W-1:0]   phase_q,
  output logic              eol_done
);
  localparam logic [PH_W-1:0] LAST4 = PH_W'(MAX_BYTES - 1);
  localparam logic [PH_W-1:0] LAST2 = PH_W'(1);

  logic four_q, eol_q, last;

  assign last     = busy && (phase_q == (four_q ? LAST4 : LAST2));
  assign ready    = !busy || (last && !eol_q);
  assign acc      = in_valid && ready;
  assign eol_done = last && eol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase_q <= '0;
      word_q  <= '0;
      four_q  <= 1'b0;
      eol_q   <= 1'b0;
    end else if (acc) begin
      busy    <= 1'b1;
      phase_q <= '0;
      word_q  <= in_word;
      four_q  <= four_next;
      eol_q   <= in_eol;
    end else if (busy) begin
      if (last) begin
        busy    <= 1'b0;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/pof_frame_ctl.sv
module pof_frame_ctl
  import pof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       in_sof,
  input  logic       in_sol,
  input  logic       eol_done,
  input  logic [1:0] cfg_fmt,
  input  logic [1:0] cfg_sub,
  output logic [1:0] fmt_q,
  output logic [1:0] sub_q,
  output logic       four_next,
  output logic       vsync_q,
  output logic       line_q
);
  logic frame_open;

  assign frame_open = acc && in_sof;
  assign four_next  = four_byte_beat(in_sof ? cfg_fmt : fmt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= FMT_YCC;
      sub_q   <= 2'd0;
      vsync_q <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      vsync_q <= frame_open;
      if (frame_open) begin
        fmt_q <= cfg_fmt;
        sub_q <= cfg_sub;
      end
      if (acc && in_sol)  line_q <= 1'b1;
      else if (eol_done)  line_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pof_byte_mux.sv
module pof_byte_mux
  import pof_pkg::*;
(
  input  logic              busy,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        fmt,
  input  logic [1:0]        sub,
  input  logic [PH_W-1:0]   phase,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] cand [MAX_BYTES];

  for (genvar f = 0; f < MAX_BYTES; f++) begin : g_fmt
    if (f == int'(FMT_YCC)) begin : g_ycc
      assign cand[f] = ycc_byte(word, sub, phase);
    end else if (f == int'(FMT_RGB)) begin : g_rgb
      assign cand[f] = rgb_byte(word, sub[0], phase);
    end else begin : g_raw
      assign cand[f] = raw_byte(word, sub[0], phase);
    end
  end

  assign data = busy ? cand[fmt] : '0;
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_sub,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_sol,
  input  logic              in_eol,
  input  logic [WORD_W-1:0] in_word,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_stb,
  output logic              out_hsync,
  output logic              out_vsync
);
  logic              acc, busy, eol_done, four_next;
  logic [WORD_W-1:0] word_q;
  logic [PH_W-1:0]   phase_q;
  logic [1:0]        fmt_q, sub_q;

  pof_beat_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_eol(in_eol), .four_next(four_next), .ready(in_ready), .acc(acc),
    .busy(busy), .word_q(word_q), .phase_q(phase_q), .eol_done(eol_done)
  );

  pof_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n), .acc(acc), .in_sof(in_sof), .in_sol(in_sol),
    .eol_done(eol_done), .cfg_fmt(cfg_fmt), .cfg_sub(cfg_sub),
    .fmt_q(fmt_q), .sub_q(sub_q), .four_next(four_next),
    .vsync_q(out_vsync), .line_q(out_hsync)
  );

  pof_byte_mux u_mux (
    .busy(busy), .word(word_q), .fmt(fmt_q), .sub(sub_q),
    .phase(phase_q), .data(out_data)
  );

  assign out_stb = busy;
endmodule

// File: rtl/pof_checker.sv
module pof_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       in_sol,
  input logic [7:0] out_data,
  input logic       out_stb,
  input logic       out_hsync,
  input logic       out_vsync,
  input logic       eol_done,
  input logic [1:0] fmt_q,
  input logic [1:0] sub_q
);
  assert_idle_bus_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |-> out_data == 8'd0);

  assert_stb_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> out_hsync);

  assert_eol_no_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eol_done |-> !in_ready);

  assert_eol_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eol_done |=> !out_hsync);

  assert_vsync_with_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vsync |-> out_stb);

  assert_vsync_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vsync |=> !out_vsync);

  assert_line_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sol) |=> (out_stb && out_hsync));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_sof) |=> ($stable(fmt_q) && $stable(sub_q)));
endmodule

bind pix_out_fmt pof_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_sol(in_sol), .out_data(out_data), .out_stb(out_stb),
  .out_hsync(out_hsync), .out_vsync(out_vsync), .eol_done(eol_done),
  .fmt_q(fmt_q), .sub_q(sub_q)
);

// File: tb/sim_pix_out_fmt.sv
module sim_pix_out_fmt;
  localparam int CLK_P = 10;
  localparam int NVEC  = 12;
  // {fmt[1:0], sub[1:0], nbytes[2:0], word[31:0], expected bytes first-in-MSB[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 3'd4, 32'hD4C3B2A1, 32'hB2A1D4C3},
    {2'd0, 2'd1, 3'd4, 32'hD4C3B2A1, 32'hD4A1B2C3},
    {2'd0, 2'd2, 3'd4, 32'hD4C3B2A1, 32'hA1B2C3D4},
    {2'd0, 2'd3, 3'd4, 32'hD4C3B2A1, 32'hA1D4C3B2},
    {2'd1, 2'd0, 3'd2, 32'hFFFFB52D, 32'hB52D0000},
    {2'd1, 2'd1, 3'd2, 32'hFFFFB52D, 32'h6D360000},
    {2'd1, 2'd2, 3'd2, 32'hFFFFB52D, 32'hB52D0000},
    {2'd1, 2'd3, 3'd2, 32'hFFFFB52D, 32'h6D360000},
    {2'd2, 2'd0, 3'd4, 32'hFD5AFEA5, 32'h02A5015A},
    {2'd2, 2'd1, 3'd4, 32'hFD5AFEA5, 32'h015A02A5},
    {2'd2, 2'd2, 3'd4, 32'hFD5AFEA5, 32'h02A5015A},
    {2'd3, 2'd1, 3'd4, 32'hFD5AFEA5, 32'h015A02A5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0, cfg_sub = 2'd0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready, out_stb, out_hsync, out_vsync;
  logic [7:0]  out_data;

  int checks = 0, fails = 0;
  int cyc = 0, cap_n = 0, hs_falls = 0, viol_zero = 0, viol_hs = 0;
  logic [7:0] cap_d [1024];
  bit         cap_v [1024];
  int         cap_c [1024];
  bit         hs_prev = 1'b0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pix_out_fmt u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_sub(cfg_sub),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_sol(in_sol),
    .in_eol(in_eol), .in_word(in_word), .out_data(out_data), .out_stb(out_stb),
    .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (out_stb) begin
        if (cap_n < 1024) begin
          cap_d[cap_n] = out_data;
          cap_v[cap_n] = out_vsync;
          cap_c[cap_n] = cyc;
          cap_n = cap_n + 1;
        end
        if (!out_hsync) viol_hs = viol_hs + 1;
      end else if (out_data != 8'd0) begin
        viol_zero = viol_zero + 1;
      end
      if (hs_prev && !out_hsync) hs_falls = hs_falls + 1;
      hs_prev = out_hsync;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_beat(input logic [31:0] w, input bit sof, input bit sol, input bit eol);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_sof = sof; in_sol = sol; in_eol = eol;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n0;
    int gap_base;
    int fall0;
    wait_cyc(3);
    // R1: reset state
    chk(out_stb == 0 && out_hsync == 0 && out_vsync == 0, "R1", "control outputs in reset",
        {out_stb, out_hsync, out_vsync}, 0);
    chk(out_data == 0 && in_ready == 1, "R1", "data and ready in reset", {out_data, in_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(out_stb == 0 && out_data == 0 && in_ready == 1, "R1", "outputs after reset release",
        {out_stb, out_data, in_ready}, 1);

    // R1/R6: default setting used for a beat that opens no frame
    cfg_fmt = 2'd2; cfg_sub = 2'd1;
    n0 = cap_n;
    send_beat(32'h44332211, 1'b0, 1'b1, 1'b1);
    idle();
    wait_cyc(6);
    chk(cap_n - n0 == 4, "R1", "default beat byte count", cap_n - n0, 4);
    chk({cap_d[n0], cap_d[n0+1], cap_d[n0+2], cap_d[n0+3]} == 32'h22114433, "R1",
        "default ycc sub0 order", {cap_d[n0], cap_d[n0+1], cap_d[n0+2], cap_d[n0+3]}, 32'h22114433);
    chk(cap_v[n0] == 0, "R9", "no vsync without frame start", cap_v[n0], 0);

    // Vector table: R2 R3 R4 R5, each a single-beat frame
    for (int i = 0; i < NVEC; i++) begin
      logic [70:0] v;
      logic [31:0] got;
      int nb;
      string tag;
      v = VEC[i];
      nb = int'(v[66:64]);
      tag = (v[70:69] == 2'd0) ? "R2" : (v[70:69] == 2'd1) ? "R3" : (v[70:69] == 2'd2) ? "R4" : "R5";
      cfg_fmt = v[70:69]; cfg_sub = v[68:67];
      n0 = cap_n;
      send_beat(v[63:32], 1'b1, 1'b1, 1'b1);
      idle();
      wait_cyc(6);
      got = '0;
      for (int k = 0; k < nb; k++) got[31-8*k -: 8] = cap_d[n0+k];
      chk(cap_n - n0 == nb, tag, $sformatf("vector %0d byte count", i), cap_n - n0, nb);
      chk(got == v[31:0], tag, $sformatf("vector %0d bytes", i), got, v[31:0]);
      chk(cap_v[n0] == 1 && (nb < 2 || cap_v[n0+1] == 0), "R9",
          $sformatf("vector %0d vsync on first byte only", i), {cap_v[n0], cap_v[n0+1]}, 2'b10);
    end

    // Multi-beat lines: R6 R8 R9 R10
    cfg_fmt = 2'd0; cfg_sub = 2'd2;
    fall0 = hs_falls;
    n0 = cap_n;
    send_beat(32'h44332211, 1'b1, 1'b1, 1'b0);
    cfg_fmt = 2'd1; cfg_sub = 2'd1;   // R6: mid-frame change must be ignored
    send_beat(32'h88776655, 1'b0, 1'b0, 1'b0);
    send_beat(32'hCCBBAA99, 1'b0, 1'b0, 1'b1);
    send_beat(32'h10FEEEDD, 1'b0, 1'b1, 1'b1);
    idle();
    wait_cyc(8);
    chk(cap_n - n0 == 16, "R6", "bytes over two lines keep 4-byte format", cap_n - n0, 16);
    chk({cap_d[n0+4], cap_d[n0+5], cap_d[n0+6], cap_d[n0+7]} == 32'h55667788, "R6",
        "beat after mid-frame change keeps order", {cap_d[n0+4], cap_d[n0+5], cap_d[n0+6], cap_d[n0+7]},
        32'h55667788);
    chk({cap_d[n0+12], cap_d[n0+13], cap_d[n0+14], cap_d[n0+15]} == 32'hDDEEFE10, "R6",
        "second line keeps frame setting", {cap_d[n0+12], cap_d[n0+13], cap_d[n0+14], cap_d[n0+15]},
        32'hDDEEFE10);
    chk(cap_c[n0+11] - cap_c[n0] == 11, "R10", "12 bytes on consecutive cycles",
        cap_c[n0+11] - cap_c[n0], 11);
    chk(cap_c[n0+12] - cap_c[n0+11] == 2, "R8", "one idle cycle between lines",
        cap_c[n0+12] - cap_c[n0+11], 2);
    chk(hs_falls - fall0 == 2, "R8", "hsync falls once per line", hs_falls - fall0, 2);
    chk(cap_v[n0] == 1 && cap_v[n0+12] == 0, "R9", "vsync on frame start not on later line",
        {cap_v[n0], cap_v[n0+12]}, 2'b10);

    // New frame applies the pending setting (R6)
    n0 = cap_n;
    cfg_fmt = 2'd1; cfg_sub = 2'd0;
    send_beat(32'h0000B52D, 1'b1, 1'b1, 1'b1);
    idle();
    wait_cyc(6);
    chk(cap_n - n0 == 2 && {cap_d[n0], cap_d[n0+1]} == 16'hB52D, "R6",
        "setting applied at next frame", {cap_d[n0], cap_d[n0+1]}, 16'hB52D);

    // Stall in the middle of a line: R7
    cfg_fmt = 2'd2; cfg_sub = 2'd0;
    n0 = cap_n;
    send_beat(32'hFD5AFEA5, 1'b1, 1'b1, 1'b0);
    idle();
    wait_cyc(5);
    chk(out_stb == 0 && out_data == 0, "R7", "stall gives idle bus", {out_stb, out_data}, 0);
    chk(out_hsync == 1, "R7", "line held high in stall", out_hsync, 1);
    gap_base = cap_n;
    send_beat(32'h00030100, 1'b0, 1'b0, 1'b1);
    idle();
    wait_cyc(6);
    chk(gap_base - n0 == 4 && cap_n - gap_base == 4, "R7", "byte counts around stall",
        cap_n - n0, 8);
    chk({cap_d[gap_base], cap_d[gap_base+1], cap_d[gap_base+2], cap_d[gap_base+3]} == 32'h01000003,
        "R7", "resume at first byte", {cap_d[gap_base], cap_d[gap_base+1], cap_d[gap_base+2],
        cap_d[gap_base+3]}, 32'h01000003);
    chk(out_hsync == 0, "R8", "line low after end of line", out_hsync, 0);

    chk(viol_zero == 0, "R7", "nonzero data without strobe", viol_zero, 0);
    chk(viol_hs == 0, "R8", "strobe outside line", viol_hs, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule